// File: doc/BRIEF.md
# Wideband Level Indicator with Dwell Hysteresis

This block sits at the very front of a receive path. It compares the magnitude of each wideband sample with two programmable thresholds, before any filtering. Its output can switch an external attenuator in or out quickly. The indicator turns on as soon as a valid sample's magnitude reaches the upper threshold. It turns off only after the signal has stayed under the lower threshold for a programmable number of clocks. This hysteresis stops the attenuator from chattering when the level hovers near a threshold.

A second output, the gain select, is the indicator delayed by 0 to 7 clocks. The downstream scaler uses it to pick which of its two gain settings to apply. The delay lets the internal gain change line up with the moment the external attenuator actually switches. Samples are two's-complement. Magnitude is their absolute value, with the most negative code saturated to the largest positive magnitude.

Top module: `lvl_indicator`

## Requirements
- R1: When a sample with `sampleValid` high has magnitude greater than or equal to `upperThresh`, `levelInd` is high after the next rising clock edge.
- R2: Magnitude is the absolute value of the two's-complement `sampleIn`. The code with only the sign bit set (-2^(MANT_W-1)) gives the largest magnitude, 2^(MANT_W-1)-1.
- R3: While `levelInd` is high, a valid sample whose magnitude is at or above `lowerThresh` keeps it high.
- R4: A sample presented with `sampleValid` low has no effect on the indicator state.
- R5: When `levelInd` is high and no count is running, a valid sample below `lowerThresh` starts a dwell count of D = `dwellCount` (D > 0). `levelInd` falls after the D-th rising edge following the edge that took that sample.
- R6: A valid sample at or above `lowerThresh` during a dwell count cancels the count. The indicator stays high, and only a later valid sample below `lowerThresh` restarts a full count.
- R7: A valid sample at or above `upperThresh` during a dwell count cancels the count, and the indicator stays high.
- R8: With `dwellCount` = 0, the first valid sample below `lowerThresh` clears `levelInd` at the next rising edge.
- R9: A running dwell count advances on every clock, including clocks without a valid sample. Further valid samples below `lowerThresh` do not restart it.
- R10: `gainSel` equals `levelInd` delayed by `delaySel` clocks (0 to 7). With 0, `gainSel` follows `levelInd` in the same cycle.
- R11: While `rstN` is low, `levelInd` and `gainSel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Marks a new wideband sample this cycle |
| sampleIn | input | MANT_W | Two's-complement wideband sample |
| upperThresh | input | MANT_W-1 | Magnitude at or above which the indicator turns on |
| lowerThresh | input | MANT_W-1 | Magnitude below which the dwell count runs |
| dwellCount | input | DWELL_W | Number of clocks under the lower threshold before release |
| delaySel | input | DLY_W | Clocks of delay from indicator to gain select |
| levelInd | output | 1 | Raw level indicator for the external attenuator |
| gainSel | output | 1 | Delayed gain select for the downstream scaler |

## Verification
The bench aims at the exact release clock of the dwell count. An off-by-one counter would release one clock early or late. A count that stalls without valid samples would hold the indicator well past the expected edge. It drives re-crossings of both thresholds in the middle of a count. A design that does not cancel, or that restarts on every low sample, leaves the indicator high or low at the wrong time. It also checks magnitudes exactly at each threshold, the saturated most-negative code, a zero dwell and every delay setting. These expose wrong comparison senses, sign handling that wraps instead of saturating, and a delay line tapped one stage off.

// File: rtl/lvl_ind_pkg.sv
package lvl_ind_pkg;

  // Comparison strobes from the datapath to the dwell controller
  typedef struct packed {
    logic hitUpper;    // valid sample with magnitude >= upper threshold
    logic aboveLower;  // valid sample with magnitude >= lower threshold
    logic belowLower;  // valid sample with magnitude < lower threshold
  } lvlStrobes_t;

  typedef enum logic [1:0] {
    LI_OFF   = 2'd0,
    LI_HOLD  = 2'd1,
    LI_DWELL = 2'd2
  } lvlState_t;

endpackage

// File: rtl/lvl_ind_path.sv
module lvl_ind_path
  import lvl_ind_pkg::*;
#(
  parameter int MANT_W = 14,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [MANT_W-1:0] sampleIn,
  input  logic [MANT_W-2:0] upperThresh,
  input  logic [MANT_W-2:0] lowerThresh,
  input  logic [DLY_W-1:0]  delaySel,
  input  logic              levelInd,
  output lvlStrobes_t       strobes,
  output logic              gainSel
);

  localparam int MAG_W   = MANT_W - 1;
  localparam int DLY_MAX = (1 << DLY_W) - 1;

  logic [MANT_W-1:0] negVal;
  logic [MAG_W-1:0]  mag;
  logic              isMostNeg;

  // Absolute value with saturation of the most negative code
  always_comb begin
    negVal    = ~sampleIn + {{(MANT_W-1){1'b0}}, 1'b1};
    isMostNeg = sampleIn[MANT_W-1] && (sampleIn[MAG_W-1:0] == '0);
    if (!sampleIn[MANT_W-1])
      mag = sampleIn[MAG_W-1:0];
    else if (isMostNeg)
      mag = '1;
    else
      mag = negVal[MAG_W-1:0];
  end

  always_comb begin
    strobes.hitUpper   = sampleValid && (mag >= upperThresh);
    strobes.aboveLower = sampleValid && (mag >= lowerThresh);
    strobes.belowLower = sampleValid && (mag <  lowerThresh);
  end

  // Alignment delay line: tap[k] is the indicator k clocks ago
  logic tap [DLY_MAX+1];
  assign tap[0] = levelInd;

  for (genvar i = 0; i < DLY_MAX; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tap[i+1] <= 1'b0;
      else       tap[i+1] <= tap[i];
    end
  end

  assign gainSel = tap[delaySel];

endmodule

// File: rtl/lvl_ind_ctrl.sv
module lvl_ind_ctrl
  import lvl_ind_pkg::*;
#(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  lvlStrobes_t        strobes,
  input  logic [DWELL_W-1:0] dwellCount,
  output logic               levelInd
);

  lvlState_t          state;
  logic [DWELL_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= LI_OFF;
      remain <= '0;
    end else if (strobes.hitUpper) begin
      state <= LI_HOLD;              // set, and cancel any running count
    end else begin
      unique case (state)
        LI_OFF: ;
        LI_HOLD: begin
          if (strobes.belowLower) begin
            if (dwellCount == '0) begin
              state <= LI_OFF;
            end else begin
              state  <= LI_DWELL;
              remain <= dwellCount;
            end
          end
        end
        LI_DWELL: begin
          if (strobes.aboveLower)
            state <= LI_HOLD;        // re-crossing cancels the count
          else if (remain == {{(DWELL_W-1){1'b0}}, 1'b1})
            state <= LI_OFF;         // terminal count
          else
            remain <= remain - {{(DWELL_W-1){1'b0}}, 1'b1};
        end
        default: state <= LI_OFF;
      endcase
    end
  end

  assign levelInd = (state != LI_OFF);

endmodule

// File: rtl/lvl_indicator.sv
module lvl_indicator
  import lvl_ind_pkg::*;
#(
  parameter int MANT_W  = 14,
  parameter int DWELL_W = 16,
  parameter int DLY_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [MANT_W-1:0]  sampleIn,
  input  logic [MANT_W-2:0]  upperThresh,
  input  logic [MANT_W-2:0]  lowerThresh,
  input  logic [DWELL_W-1:0] dwellCount,
  input  logic [DLY_W-1:0]   delaySel,
  output logic               levelInd,
  output logic               gainSel
);

  lvlStrobes_t strobes;

  lvl_ind_path #(.MANT_W(MANT_W), .DLY_W(DLY_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleIn    (sampleIn),
    .upperThresh (upperThresh),
    .lowerThresh (lowerThresh),
    .delaySel    (delaySel),
    .levelInd    (levelInd),
    .strobes     (strobes),
    .gainSel     (gainSel)
  );

  lvl_ind_ctrl #(.DWELL_W(DWELL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dwellCount (dwellCount),
    .levelInd   (levelInd)
  );

endmodule

// File: rtl/lvl_indicator_chk.sv
module lvl_indicator_chk #(
  parameter int MANT_W  = 14,
  parameter int DWELL_W = 16,
  parameter int DLY_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleValid,
  input logic [MANT_W-1:0]  sampleIn,
  input logic [MANT_W-2:0]  upperThresh,
  input logic [MANT_W-2:0]  lowerThresh,
  input logic [DWELL_W-1:0] dwellCount,
  input logic [DLY_W-1:0]   delaySel,
  input logic               levelInd,
  input logic               gainSel
);

  localparam int MAG_W = MANT_W - 1;

  logic posValid;
  assign posValid = sampleValid && !sampleIn[MANT_W-1];

  // R1: non-negative sample at or above upper threshold sets the indicator
  a_r1_set_on_upper: assert property (@(posedge clk) disable iff (!rstN)
    posValid && (sampleIn[MAG_W-1:0] >= upperThresh) |=> levelInd);

  // R3: active indicator held by a sample at or above the lower threshold
  a_r3_hold_at_lower: assert property (@(posedge clk) disable iff (!rstN)
    levelInd && posValid && (sampleIn[MAG_W-1:0] >= lowerThresh) |=> levelInd);

  // R4: no rise without a valid sample
  a_r4_no_rise_idle: assert property (@(posedge clk) disable iff (!rstN)
    !levelInd && !sampleValid |=> !levelInd);

  // R10: zero delay passes the indicator straight through
  a_r10_zero_delay: assert property (@(posedge clk) disable iff (!rstN)
    (delaySel == '0) |-> (gainSel == levelInd));

  // R10: unit delay lags the indicator by one clock
  a_r10_one_delay: assert property (@(posedge clk) disable iff (!rstN)
    (delaySel == DLY_W'(1)) |-> (gainSel == $past(levelInd)));

  // R11: outputs low during reset
  always_comb begin
    if (!rstN) begin
      a_r11_reset_low: assert (!levelInd);
    end
  end

endmodule

bind lvl_indicator lvl_indicator_chk #(
  .MANT_W(MANT_W), .DWELL_W(DWELL_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
  .upperThresh(upperThresh), .lowerThresh(lowerThresh),
  .dwellCount(dwellCount), .delaySel(delaySel),
  .levelInd(levelInd), .gainSel(gainSel)
);

// File: tb/lvl_indicator_test.sv
module lvl_indicator_test;

  localparam int CLK_PERIOD = 10;
  localparam int MANT_W     = 14;
  localparam int DWELL_W    = 16;
  localparam int DLY_W      = 3;
  localparam int DLY_MAX    = (1 << DLY_W) - 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               sampleValid = 1'b0;
  logic [MANT_W-1:0]  sampleIn = '0;
  logic [MANT_W-2:0]  upperThresh = '0;
  logic [MANT_W-2:0]  lowerThresh = '0;
  logic [DWELL_W-1:0] dwellCount = '0;
  logic [DLY_W-1:0]   delaySel = '0;
  logic               levelInd;
  logic               gainSel;

  lvl_indicator #(.MANT_W(MANT_W), .DWELL_W(DWELL_W), .DLY_W(DLY_W)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .upperThresh(upperThresh), .lowerThresh(lowerThresh),
    .dwellCount(dwellCount), .delaySel(delaySel),
    .levelInd(levelInd), .gainSel(gainSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic  ind;
    logic  gain;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  logic expHist [DLY_MAX];
  bit   done = 0;

  // configuration applied with the next step
  int nextUpper = 1000;
  int nextLower = 500;
  int nextDwell = 3;
  int nextDly   = 2;

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // driver: one clock per call; pushes the expected post-edge outputs
  task automatic step(input logic v, input int s, input logic eInd, input string tag);
    expItem_t it;
    @(negedge clk);
    upperThresh = (MANT_W-1)'(nextUpper);
    lowerThresh = (MANT_W-1)'(nextLower);
    dwellCount  = DWELL_W'(nextDwell);
    delaySel    = DLY_W'(nextDly);
    sampleValid = v;
    sampleIn    = MANT_W'(s);
    it.ind  = eInd;
    it.gain = (nextDly == 0) ? eInd : expHist[nextDly-1];
    for (int i = DLY_MAX-1; i > 0; i--) expHist[i] = expHist[i-1];
    expHist[0] = eInd;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        check(levelInd, it.ind,  {it.tag, " levelInd"});
        check(gainSel,  it.gain, {it.tag, " gainSel"});
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DLY_MAX; i++) expHist[i] = 1'b0;
    repeat (3) @(negedge clk);
    check(levelInd, 1'b0, "R11 reset levelInd");
    check(gainSel,  1'b0, "R11 reset gainSel");
    rstN = 1'b1;

    // R1 exact threshold, R3 hold, R5 dwell of 3, R9 idle and low samples
    step(1, 999, 0, "R1 just below upper");
    step(1, 1000, 1, "R1 equal upper sets");
    step(1, 700, 1, "R3 between thresholds holds");
    step(1, 500, 1, "R3 equal lower holds");
    step(1, 100, 1, "R5 fall starts count");
    step(0, 0, 1, "R9 count across idle");
    step(1, 50, 1, "R9 low sample no restart");
    step(0, 0, 0, "R5 release at terminal count");
    step(0, 6000, 0, "R4 invalid large sample ignored");
    step(0, -8000, 0, "R4 invalid negative ignored");

    // R2 negative set, R6 cancel by lower re-crossing
    step(1, -1200, 1, "R2 negative magnitude sets");
    step(1, 10, 1, "R6 fall starts count");
    step(0, 0, 1, "R6 counting");
    step(1, 600, 1, "R6 re-crossing cancels");
    step(0, 0, 1, "R6 held after cancel");
    step(0, 0, 1, "R6 held after cancel");
    step(0, 0, 1, "R6 held after cancel");
    step(1, -10, 1, "R6 fresh fall restarts");
    step(0, 0, 1, "R6 full count");
    step(0, 0, 1, "R6 full count");
    step(0, 0, 0, "R6 release after full count");

    // R7 upper crossing cancels count
    step(1, 3000, 1, "R7 set");
    step(1, 10, 1, "R7 fall starts count");
    step(1, 1500, 1, "R7 upper cancels count");
    step(0, 0, 1, "R7 held");
    step(0, 0, 1, "R7 held");
    step(0, 0, 1, "R7 held past old terminal");
    step(1, 10, 1, "R7 fresh fall");
    step(1, 20, 1, "R9 low sample no restart");
    step(1, 30, 1, "R9 low sample no restart");
    step(0, 0, 0, "R7 release");

    // R8 zero dwell
    nextDwell = 0;
    step(1, 2000, 1, "R8 set");
    step(1, 500, 1, "R8 equal lower holds");
    step(1, 499, 0, "R8 zero dwell clears at once");
    step(0, 0, 0, "R8 stays clear");

    // R2 saturation of the most negative code
    nextUpper = 8191;
    step(1, 8190, 0, "R2 below max upper");
    step(1, -8191, 1, "R2 -8191 reaches 8191");
    step(1, 0, 0, "R8 clear");
    step(1, -8192, 1, "R2 most negative saturates");
    step(1, 0, 0, "R8 clear");

    // R10 every delay setting
    nextUpper = 1000;
    for (int d = 0; d <= DLY_MAX; d++) begin
      nextDly = d;
      for (int k = 0; k < DLY_MAX+1; k++) step(0, 0, 0, "R10 settle");
      step(1, 1200, 1, "R10 pulse rise");
      step(1, 800, 1, "R10 pulse hold");
      step(1, 0, 0, "R10 pulse fall");
      for (int k = 0; k < DLY_MAX+1; k++) step(0, 0, 0, "R10 tail");
    end

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule